// File: doc/BRIEF.md
# I2C Register Front End with Auto-Increment

This block is the serial-bus side of a small LED blink controller. It is a slave on a two-wire I2C bus and lets a bus master reach a six-entry register file. Both bus lines are brought onto the system clock and cleaned by a short majority filter. The block then finds START and STOP conditions, answers only to its fixed 7-bit address, and takes a control byte whose low bits point at one register. After that it streams data bytes in either direction. When the control byte's increment flag is set, the pointer steps forward after every data byte.

The first register is read-only and shows the logic levels of the LED pins. The other five registers hold the two blink periods, the two duty values and the LED source selector. These five are exported as plain outputs to the blink logic. The SDA output is an open-drain enable: when it is high, the pad pulls the line low.

A read transfer starts at whatever the pointer currently holds. To read a register, a master writes the control byte, issues a repeated START and then sends the read address.

Top module: `i2c_blink_regs`

## Requirements
- R1: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) releases SDA and returns to idle. A transfer cut off by a STOP before its data byte changes no register.
- R2: The address byte 8'hC4 (write) or 8'hC5 (read), that is 7-bit address 7'h62 with the R/W flag in bit 0, is acknowledged by holding SDA low through the ninth clock. Any other address gets no acknowledge, and the block ignores every following byte (no acknowledge, no write) until the next START.
- R3: The first byte after an acknowledged write address is stored as the control byte and acknowledged. Its bits [2:0] are the pointer: 0 pin levels, 1 period 0, 2 duty 0, 3 period 1, 4 duty 1, 5 LED selector.
- R4: Each later data byte of a write is acknowledged and stored in the register the pointer selects, and it appears on that register's output port.
- R5: When control bit 4 is set, the pointer advances by one after every data byte that is written or read. From 5, 6 or 7 it goes to 0. Only bits [2:0] change. When bit 4 is clear, the pointer stays put.
- R6: Register 0 reads as {4'b0000, pin levels}. A write to it is acknowledged and discarded.
- R7: Pointer values 6 and 7 read as 8'h00. Writes to them are acknowledged and discarded.
- R8: A read sends the selected register MSB first and sends one more byte for every master acknowledge. A master NACK ends the read, and the slave releases SDA.
- R9: After reset, the periods and duties are 8'h00, the LED selector is 8'h55 and SDA is released.
- R10: The slave starts driving SDA low only while SCL is low, and keeps its SDA output steady while SCL is high.
- R11: A pulse on SCL that lasts a single system clock is ignored and does not count as a bus clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| pin_lvl | input | 4 | Levels of the LED pins, read through register 0 |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| presc0 | output | 8 | Blink period register 0 |
| duty0 | output | 8 | Blink duty register 0 |
| presc1 | output | 8 | Blink period register 1 |
| duty1 | output | 8 | Blink duty register 1 |
| led_sel | output | 8 | LED source selector |

## Verification
The hardest cases to reach are pointer wrap from the unused values 6 and 7 and a one-clock spike on SCL in the middle of a byte, because neither shows up in ordinary register traffic. The stimulus loads control byte 8'h17 and streams three bytes, so the pointer goes 7 to 0 to 1 and only the third byte lands. In a separate write, the bench drives a single-clock SCL pulse inside the low phase of one data bit. It then checks that the stored byte keeps its intended value instead of taking an extra shifted bit.

// File: rtl/i2cr_pkg.sv
package i2cr_pkg;

    localparam int REG_COUNT = 6;
    localparam int PTR_W     = 3;
    localparam int AI_BIT    = 4;
    localparam logic [7:0] SEL_RESET = 8'h55;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CTRL,
        ST_ACK_WR,
        ST_WDATA,
        ST_RDATA,
        ST_RACK
    } bus_state_t;

    typedef struct packed {
        logic             en;
        logic [PTR_W-1:0] addr;
        logic [7:0]       data;
    } wr_req_t;

    typedef struct packed {
        logic [7:0] presc0;
        logic [7:0] duty0;
        logic [7:0] presc1;
        logic [7:0] duty1;
        logic [7:0] sel;
    } blink_cfg_t;

    function automatic logic vote3(input logic [2:0] v);
        return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
    endfunction

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p >= PTR_W'(REG_COUNT - 1)) ? '0 : p + PTR_W'(1);
    endfunction

endpackage

// File: rtl/i2cr_glitch_filter.sv
module i2cr_glitch_filter #(
    parameter int SYNC_STAGES = 2,
    parameter bit IDLE_LEVEL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    import i2cr_pkg::*;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= {SYNC_STAGES{IDLE_LEVEL}};
            hist_q <= {3{IDLE_LEVEL}};
            out_q  <= IDLE_LEVEL;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], din};
            hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
            out_q  <= vote3(hist_q);
        end
    end

    assign dout = out_q;

endmodule

// File: rtl/i2cr_engine.sv
module i2cr_engine #(
    parameter logic [6:0] DEV_ADDR = 7'h62
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    scl_f,
    input  logic                    sda_f,
    input  logic [7:0]              rd_data,
    output logic                    sda_oe,
    output logic [i2cr_pkg::PTR_W-1:0] ptr,
    output i2cr_pkg::wr_req_t       wr
);
    import i2cr_pkg::*;

    bus_state_t state;
    logic       scl_q, sda_q;
    logic [3:0] cnt;
    logic [7:0] shreg;
    logic [7:0] ctrl;
    logic       rw, mack, oe;

    logic start_c, stop_c, rise_c, fall_c, byte_full, ctrl_load;
    assign start_c   = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_c    = scl_f & scl_q & ~sda_q & sda_f;
    assign rise_c    = scl_f & ~scl_q;
    assign fall_c    = ~scl_f & scl_q;
    assign byte_full = (cnt == 4'd8);
    assign ctrl_load = (state == ST_CTRL) && fall_c && byte_full && !start_c && !stop_c;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
            shreg <= '0;
            ctrl  <= '0;
            rw    <= 1'b0;
            mack  <= 1'b0;
            oe    <= 1'b0;
            wr    <= '0;
        end else begin
            wr.en <= 1'b0;
            if (start_c) begin
                state <= ST_ADDR;
                cnt   <= '0;
                oe    <= 1'b0;
            end else if (stop_c) begin
                state <= ST_IDLE;
                oe    <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR, ST_CTRL, ST_WDATA: begin
                        if (rise_c && !byte_full) begin
                            shreg <= {shreg[6:0], sda_f};
                            cnt   <= cnt + 4'd1;
                        end else if (fall_c && byte_full) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    rw    <= shreg[0];
                                    oe    <= 1'b1;
                                    state <= ST_ACK_ADDR;
                                end else begin
                                    state <= ST_IDLE;
                                end
                            end else if (state == ST_CTRL) begin
                                ctrl  <= shreg;
                                oe    <= 1'b1;
                                state <= ST_ACK_WR;
                            end else begin
                                wr.en   <= 1'b1;
                                wr.addr <= ctrl[PTR_W-1:0];
                                wr.data <= shreg;
                                if (ctrl[AI_BIT])
                                    ctrl[PTR_W-1:0] <= step_ptr(ctrl[PTR_W-1:0]);
                                oe    <= 1'b1;
                                state <= ST_ACK_WR;
                            end
                        end
                    end
                    ST_ACK_ADDR: if (fall_c) begin
                        cnt <= '0;
                        if (rw) begin
                            shreg <= rd_data;
                            oe    <= ~rd_data[7];
                            state <= ST_RDATA;
                            if (ctrl[AI_BIT])
                                ctrl[PTR_W-1:0] <= step_ptr(ctrl[PTR_W-1:0]);
                        end else begin
                            oe    <= 1'b0;
                            state <= ST_CTRL;
                        end
                    end
                    ST_ACK_WR: if (fall_c) begin
                        oe    <= 1'b0;
                        cnt   <= '0;
                        state <= ST_WDATA;
                    end
                    ST_RDATA: if (fall_c) begin
                        if (cnt == 4'd7) begin
                            oe    <= 1'b0;
                            state <= ST_RACK;
                        end else begin
                            cnt   <= cnt + 4'd1;
                            oe    <= ~shreg[6];
                            shreg <= {shreg[6:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (rise_c) begin
                            mack <= ~sda_f;
                        end else if (fall_c) begin
                            if (mack) begin
                                shreg <= rd_data;
                                oe    <= ~rd_data[7];
                                cnt   <= '0;
                                state <= ST_RDATA;
                                if (ctrl[AI_BIT])
                                    ctrl[PTR_W-1:0] <= step_ptr(ctrl[PTR_W-1:0]);
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign sda_oe = oe;
    assign ptr    = ctrl[PTR_W-1:0];

    // R10: the slave begins pulling SDA low only in the SCL low phase
    assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_f);

    // R4: register writes are issued only while SCL is low
    assert_write_scl_low_R4: assert property (@(posedge clk) disable iff (rst)
        wr.en |-> !scl_f);

    // R1: a STOP leaves SDA released
    assert_stop_release_R1: assert property (@(posedge clk) disable iff (rst)
        $past(stop_c) |-> !sda_oe);

    // R5: control bits outside the pointer change only on a control byte
    assert_ctrl_keep_R5: assert property (@(posedge clk) disable iff (rst)
        !ctrl_load |=> $stable({ctrl[7:5], ctrl[3]}));

endmodule

// File: rtl/i2cr_regs.sv
module i2cr_regs #(
    parameter int PIN_COUNT = 4
) (
    input  logic                       clk,
    input  logic                       rst,
    input  i2cr_pkg::wr_req_t          wr,
    input  logic [i2cr_pkg::PTR_W-1:0] rd_ptr,
    input  logic [PIN_COUNT-1:0]       pins,
    output logic [7:0]                 rd_data,
    output i2cr_pkg::blink_cfg_t       cfg
);
    import i2cr_pkg::*;

    localparam int PAD_W = 8 - PIN_COUNT;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg        <= '0;
            cfg.sel    <= SEL_RESET;
        end else if (wr.en) begin
            case (wr.addr)
                3'd1: cfg.presc0 <= wr.data;
                3'd2: cfg.duty0  <= wr.data;
                3'd3: cfg.presc1 <= wr.data;
                3'd4: cfg.duty1  <= wr.data;
                3'd5: cfg.sel    <= wr.data;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (rd_ptr)
            3'd0:    rd_data = {{PAD_W{1'b0}}, pins};
            3'd1:    rd_data = cfg.presc0;
            3'd2:    rd_data = cfg.duty0;
            3'd3:    rd_data = cfg.presc1;
            3'd4:    rd_data = cfg.duty1;
            3'd5:    rd_data = cfg.sel;
            default: rd_data = 8'h00;
        endcase
    end

    // R6 / R7: writes to the pin register or unused slots leave the file as is
    assert_ro_slots_R7: assert property (@(posedge clk) disable iff (rst)
        (wr.en && (wr.addr == 3'd0 || wr.addr > 3'd5)) |=> $stable(cfg));

    // R9: first cycle after reset shows the reset contents
    assert_reset_vals_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg.sel == SEL_RESET && cfg.presc0 == 8'h00 &&
                        cfg.duty0 == 8'h00 && cfg.presc1 == 8'h00 && cfg.duty1 == 8'h00));

endmodule

// File: rtl/i2c_blink_regs.sv
module i2c_blink_regs #(
    parameter logic [6:0] DEV_ADDR    = 7'h62,
    parameter int         PIN_COUNT   = 4,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [PIN_COUNT-1:0] pin_lvl,
    output logic                 sda_oe,
    output logic [7:0]           presc0,
    output logic [7:0]           duty0,
    output logic [7:0]           presc1,
    output logic [7:0]           duty1,
    output logic [7:0]           led_sel
);
    import i2cr_pkg::*;

    logic [1:0] raw_lines, clean_lines;
    assign raw_lines = {scl_i, sda_i};

    for (genvar g = 0; g < 2; g++) begin : g_line_filt
        i2cr_glitch_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .IDLE_LEVEL (1'b1)
        ) u_filt (
            .clk (clk),
            .rst (rst),
            .din (raw_lines[g]),
            .dout(clean_lines[g])
        );
    end

    logic [PTR_W-1:0] ptr;
    logic [7:0]       rd_data;
    wr_req_t          wr;
    blink_cfg_t       cfg;

    i2cr_engine #(.DEV_ADDR(DEV_ADDR)) u_engine (
        .clk    (clk),
        .rst    (rst),
        .scl_f  (clean_lines[1]),
        .sda_f  (clean_lines[0]),
        .rd_data(rd_data),
        .sda_oe (sda_oe),
        .ptr    (ptr),
        .wr     (wr)
    );

    i2cr_regs #(.PIN_COUNT(PIN_COUNT)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr     (wr),
        .rd_ptr (ptr),
        .pins   (pin_lvl),
        .rd_data(rd_data),
        .cfg    (cfg)
    );

    assign presc0  = cfg.presc0;
    assign duty0   = cfg.duty0;
    assign presc1  = cfg.presc1;
    assign duty1   = cfg.duty1;
    assign led_sel = cfg.sel;

endmodule

// File: tb/i2c_blink_regs_tb.sv
module i2c_blink_regs_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_drv = 1'b1;
    logic       sda_drv = 1'b1;
    logic [3:0] pins = 4'hA;
    logic       sda_oe;
    logic [7:0] presc0, duty0, presc1, duty1, led_sel;
    logic       sda_line;

    assign sda_line = sda_drv & ~sda_oe;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_blink_regs dut_i (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .pin_lvl(pins),
        .sda_oe(sda_oe), .presc0(presc0), .duty0(duty0), .presc1(presc1),
        .duty1(duty1), .led_sel(led_sel)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit finished = 1'b0;

    // behavioural reference state
    logic [7:0] m_reg [0:7];
    int         m_ptr = 0;
    bit         m_ai  = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input int p);
        if (p == 0) return {4'b0000, pins};
        if (p <= 5) return m_reg[p];
        return 8'h00;
    endfunction

    function automatic int model_step(input int p);
        return (p >= 5) ? 0 : p + 1;
    endfunction

    // cycle-by-cycle comparison of the exported registers (R4, R9)
    always @(negedge clk) begin
        if (cmp_en && !rst) begin
            chk({presc0, duty0, presc1, duty1, led_sel} ==
                {m_reg[1], m_reg[2], m_reg[3], m_reg[4], m_reg[5]}, "R4 regs",
                {presc0, duty0, presc1, duty1, led_sel},
                {m_reg[1], m_reg[2], m_reg[3], m_reg[4], m_reg[5]});
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b0; tick(16);
        scl_drv = 1'b0; tick(8);
    endtask

    task automatic bus_rstart();
        sda_drv = 1'b1; tick(8);
        scl_drv = 1'b1; tick(16);
        sda_drv = 1'b0; tick(16);
        scl_drv = 1'b0; tick(8);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; tick(8);
        scl_drv = 1'b1; tick(16);
        sda_drv = 1'b1; tick(16);
    endtask

    // kind: 0 address/ignored, 1 control byte, 2 data byte
    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input int kind,
                             input bit glitch, input string tag);
        for (int i = 7; i >= 0; i--) begin
            if (glitch && i == 3) begin
                tick(4); scl_drv = 1'b1; tick(1); scl_drv = 1'b0; tick(3);
            end else begin
                tick(8);
            end
            sda_drv = b[i]; tick(8);
            scl_drv = 1'b1; tick(16);
            scl_drv = 1'b0;
        end
        cmp_en = 1'b0;
        tick(8); sda_drv = 1'b1; tick(6);
        if (kind == 1) begin
            m_ptr = int'(b[2:0]);
            m_ai  = b[4];
        end else if (kind == 2) begin
            if (m_ptr >= 1 && m_ptr <= 5) m_reg[m_ptr] = b;
            if (m_ai) m_ptr = model_step(m_ptr);
        end
        cmp_en = 1'b1;
        tick(2); scl_drv = 1'b1; tick(8);
        chk(sda_oe == exp_ack, tag, {39'b0, sda_oe}, {39'b0, exp_ack});
        tick(8); scl_drv = 1'b0;
    endtask

    task automatic read_byte(input bit master_ack, input string tag);
        logic [7:0] got, expv;
        bit         steady;
        expv   = model_read(m_ptr);
        steady = 1'b1;
        if (m_ai) m_ptr = model_step(m_ptr);
        for (int i = 7; i >= 0; i--) begin
            logic oe_mid;
            tick(16); scl_drv = 1'b1; tick(8);
            got[i] = sda_line; oe_mid = sda_oe;
            tick(8);
            if (sda_oe != oe_mid) steady = 1'b0;
            scl_drv = 1'b0;
        end
        chk(got == expv, tag, {32'b0, got}, {32'b0, expv});
        chk(steady, "R10 sda steady while scl high", {39'b0, steady}, 40'd1);
        tick(8); sda_drv = ~master_ack; tick(8);
        scl_drv = 1'b1; tick(16); scl_drv = 1'b0;
        tick(2); sda_drv = 1'b1;
    endtask

    initial begin
        for (int k = 0; k < 8; k++) m_reg[k] = 8'h00;
        m_reg[5] = 8'h55;
        tick(10); rst = 1'b0; tick(4);
        // R9 reset state
        chk({presc0, duty0, presc1, duty1, led_sel} == 40'h00_00_00_00_55, "R9 reset regs",
            {presc0, duty0, presc1, duty1, led_sel}, 40'h00_00_00_00_55);
        chk(sda_oe == 1'b0, "R9 sda released", {39'b0, sda_oe}, 40'd0);
        cmp_en = 1'b1;

        // R2 R3 R4 R5: burst write with auto-increment from pointer 1
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h11, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'h2B, 1, 2, 0, "R4 data ack");
        send_byte(8'h80, 1, 2, 0, "R4 data ack");
        send_byte(8'h0A, 1, 2, 0, "R4 data ack");
        send_byte(8'hC0, 1, 2, 0, "R4 data ack");
        send_byte(8'hE4, 1, 2, 0, "R5 data ack before wrap");
        bus_stop();

        // R8 R5 R6: burst read from 1, wrapping into the pin register
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h11, 1, 1, 0, "R3 ctrl ack");
        bus_rstart();
        send_byte(8'hC5, 1, 0, 0, "R2 read addr ack");
        read_byte(1, "R8 read reg1");
        read_byte(1, "R8 read reg2");
        read_byte(1, "R8 read reg3");
        read_byte(1, "R8 read reg4");
        read_byte(1, "R8 read reg5");
        read_byte(0, "R5 wrap read pins R6");
        chk(sda_oe == 1'b0, "R8 released after nack", {39'b0, sda_oe}, 40'd0);
        bus_stop();

        // R2: foreign address, everything after it ignored
        bus_start();
        send_byte(8'hC6, 0, 0, 0, "R2 foreign addr nack");
        send_byte(8'h11, 0, 0, 0, "R2 ignored byte nack");
        send_byte(8'h55, 0, 0, 0, "R2 ignored byte nack");
        bus_stop();

        // R5: no auto-increment, two bytes land in the same register
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h02, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'h11, 1, 2, 0, "R5 fixed ptr ack");
        send_byte(8'h22, 1, 2, 0, "R5 fixed ptr ack");
        bus_stop();

        // R6: pin register write discarded, read shows pins
        pins = 4'h5;
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h00, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'hAA, 1, 2, 0, "R6 ro write ack");
        bus_rstart();
        send_byte(8'hC5, 1, 0, 0, "R2 read addr ack");
        read_byte(0, "R6 pin read");
        bus_stop();

        // R7: slot 6 ignores writes and reads zero
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h06, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'h5A, 1, 2, 0, "R7 unused write ack");
        bus_rstart();
        send_byte(8'hC5, 1, 0, 0, "R2 read addr ack");
        read_byte(0, "R7 unused reads zero");
        bus_stop();

        // R5 R7: wrap from slot 7 through 0 into 1
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h17, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'h33, 1, 2, 0, "R7 slot7 write ack");
        send_byte(8'h44, 1, 2, 0, "R6 slot0 write ack");
        send_byte(8'h99, 1, 2, 0, "R5 wrapped write ack");
        bus_stop();

        // R11: single-clock SCL spike inside a data bit
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h02, 1, 1, 0, "R3 ctrl ack");
        send_byte(8'h3C, 1, 2, 1, "R11 glitched byte ack");
        bus_stop();
        chk(duty0 == 8'h3C, "R11 glitch rejected", {32'b0, duty0}, 40'h3C);

        // R1: STOP before any data, pointer kept, next read starts there
        bus_start();
        send_byte(8'hC4, 1, 0, 0, "R2 write addr ack");
        send_byte(8'h13, 1, 1, 0, "R3 ctrl ack");
        bus_stop();
        chk(sda_oe == 1'b0, "R1 idle after stop", {39'b0, sda_oe}, 40'd0);
        bus_start();
        send_byte(8'hC5, 1, 0, 0, "R2 read addr ack");
        read_byte(0, "R1 read after aborted write");
        bus_stop();

        tick(20);
        cmp_en = 1'b0;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule